// File: doc/BRIEF.md
# Serial Register Target for an Isolated Converter Front End

This block is the serial-bus side of a small converter front end. A host reaches its register space through 16-bit SPI frames in mode 0. Each frame is shifted least-significant bit first on both data lines. A frame carries a 5-bit register address in bits 15:11, a write flag in bit 10 and a 10-bit data field in bits 9:0.

Reads are split across two chip-select periods. A frame with the write flag clear names an address. The register value is then shifted back out during the next frame. Two results from the conversion path arrive on parallel inputs and are mirrored into read-only registers.

Configuration registers change only while a key value sits in the write-enable register. Every configuration register has a verification twin sixteen addresses higher. Whenever any twin disagrees with its primary, a fault flag is raised. One configuration bit selects the external reference and is driven onto a pin. The serial clock, chip select and data input are oversampled and synchronised into the system clock domain.

Top module: `spireg_target`

## Requirements
- R1: Frames are 16 bits with address in bits 15:11, write flag in bit 10, data in bits 9:0. Both MOSI and MISO carry bit 0 first. MOSI is sampled on SCLK rising edges and MISO changes after falling edges.
- R2: A complete frame with bit 10 clear is a read request. The following frame returns the addressed value in bits 9:0 with bits 15:10 zero. A frame that follows a write frame, or follows no request, returns all zeros.
- R3: Address 0x00 returns `raw_code` and address 0x01 returns `filt_code`, each sampled when chip select falls for the reply frame. Writes to these addresses do nothing.
- R4: Address 0x0C is the write-enable register. It is always writable and readable. The block is unlocked only while it holds 0x294, and writing any other value locks it.
- R5: While locked, writes to 0x03–0x0A and 0x13–0x1A leave every register unchanged.
- R6: While unlocked, writes to 0x00–0x02, 0x0B, 0x0D–0x12 and 0x1B–0x1F store nothing.
- R7: Reads of 0x0B, 0x0D–0x12 and 0x1B–0x1F return zero.
- R8: Registers 0x03–0x0A and their twins 0x13–0x1A hold and return the last value written while unlocked.
- R9: Bit 0 of the flags register at 0x02 is 1 while any register in 0x03–0x0A differs from its twin, and 0 once all eight pairs match. Bits 9:1 of that register read 0.
- R10: `ext_ref_sel` equals bit 5 of register 0x09.
- R11: A chip-select period with other than exactly 16 SCLK rising edges writes nothing and cancels any pending read reply.
- R12: After reset all registers read zero, no reply is pending, `ext_ref_sel` is 0, and `miso` is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host, LSB first |
| miso | output | 1 | Serial data to host, LSB first; 0 when deselected |
| raw_code | input | 10 | Unfiltered conversion result shown at 0x00 |
| filt_code | input | 10 | Filtered conversion result shown at 0x01 |
| ext_ref_sel | output | 1 | External reference select, bit 5 of 0x09 |

## Verification
All internal state is visible only through reply frames, so a corrupted register or a wrong lock state appears in the frame after the read request that names it. That is at most one chip-select period late. A stuck or stale fault flag shows in bit 0 of the next flags read. A wrong comparison shows as a flag that disagrees with the twin pattern the host wrote. A wrong bit order or sampling edge corrupts every reply at once. A mis-decoded write surfaces during the next full sweep of the 32 addresses. The external-reference pin follows register 0x09 within a few clocks of chip select rising.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int FRAME_W   = 16;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 10;
    localparam int CFG_COUNT = 8;
    localparam int FAULT_BIT = 0;
    localparam int EXTREF_BIT = 5;

    localparam logic [ADDR_W-1:0] A_RAW     = 5'h00;
    localparam logic [ADDR_W-1:0] A_FILT    = 5'h01;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 5'h02;
    localparam logic [ADDR_W-1:0] A_CFG_LO  = 5'h03;
    localparam logic [ADDR_W-1:0] A_EXTREF  = 5'h09;
    localparam logic [ADDR_W-1:0] A_WEN     = 5'h0C;
    localparam logic [ADDR_W-1:0] SHD_OFS   = 5'h10;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 10'h294;
    localparam int EXTREF_IDX = int'(A_EXTREF) - int'(A_CFG_LO);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
        return A_CFG_LO + ADDR_W'(idx);
    endfunction

    function automatic logic [ADDR_W-1:0] shd_addr(input int idx);
        return A_CFG_LO + SHD_OFS + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/spireg_pin_sync.sv
module spireg_pin_sync #(
    parameter int         STAGES  = 2,
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [0:STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s <= STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s <= STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q    = stg[STAGES-1];
    assign rise = stg[STAGES-1] & ~stg[STAGES];
    assign fall = ~stg[STAGES-1] & stg[STAGES];
endmodule

// File: rtl/spireg_shifter.sv
module spireg_shifter
    import spireg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               selected,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               mosi_q,
    input  logic [FRAME_W-1:0] load_word,
    output logic               frame_done,
    output logic               frame_ok,
    output frame_t             rx_word,
    output logic               miso
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic [CNT_W-1:0]   bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr      <= '0;
            tx_sr      <= '0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (cs_fall) begin
                tx_sr   <= load_word;
                rx_sr   <= '0;
                bit_cnt <= '0;
            end else if (selected) begin
                if (sclk_rise) begin
                    rx_sr <= {mosi_q, rx_sr[FRAME_W-1:1]};
                    if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall) tx_sr <= {1'b0, tx_sr[FRAME_W-1:1]};
            end
            if (cs_rise) begin
                frame_done <= 1'b1;
                frame_ok   <= (bit_cnt == CNT_FULL);
            end
        end
    end

    assign rx_word = frame_t'(rx_sr);
    assign miso    = selected & tx_sr[0];

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !cs_fall) |=> $stable(tx_sr)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R11
endmodule

// File: rtl/spireg_regs.sv
module spireg_regs
    import spireg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_done,
    input  logic               frame_ok,
    input  frame_t             rx_word,
    input  logic [DATA_W-1:0]  raw_code,
    input  logic [DATA_W-1:0]  filt_code,
    output logic [FRAME_W-1:0] load_word,
    output logic               ext_ref_sel
);
    logic [CFG_COUNT-1:0][DATA_W-1:0] cfg;
    logic [CFG_COUNT-1:0][DATA_W-1:0] shd;
    logic [CFG_COUNT-1:0]             pair_diff;
    logic [DATA_W-1:0]                wen;
    logic [DATA_W-1:0]                rdata;
    logic [DATA_W-1:0]                flags;
    logic [ADDR_W-1:0]                rd_addr;
    logic                             rd_pend;
    logic                             mv_fault;
    logic                             unlocked;
    logic                             wr_go;

    assign unlocked = (wen == UNLOCK_KEY);
    assign wr_go    = frame_done & frame_ok & rx_word.wr;

    generate
        for (genvar g = 0; g < CFG_COUNT; g++) begin : g_pair
            assign pair_diff[g] = (cfg[g] != shd[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            shd      <= '0;
            wen      <= '0;
            rd_pend  <= 1'b0;
            rd_addr  <= '0;
            mv_fault <= 1'b0;
        end else begin
            mv_fault <= |pair_diff;
            if (wr_go && rx_word.addr == A_WEN) wen <= rx_word.data;
            for (int i = 0; i < CFG_COUNT; i++) begin
                if (wr_go && unlocked && rx_word.addr == cfg_addr(i)) cfg[i] <= rx_word.data;
                if (wr_go && unlocked && rx_word.addr == shd_addr(i)) shd[i] <= rx_word.data;
            end
            if (frame_done) begin
                rd_pend <= frame_ok & ~rx_word.wr;
                rd_addr <= rx_word.addr;
            end
        end
    end

    always_comb begin
        flags            = '0;
        flags[FAULT_BIT] = mv_fault;
        rdata            = '0;
        case (rd_addr)
            A_RAW:   rdata = raw_code;
            A_FILT:  rdata = filt_code;
            A_FLAGS: rdata = flags;
            A_WEN:   rdata = wen;
            default: rdata = '0;
        endcase
        for (int i = 0; i < CFG_COUNT; i++) begin
            if (rd_addr == cfg_addr(i)) rdata = cfg[i];
            if (rd_addr == shd_addr(i)) rdata = shd[i];
        end
    end

    assign load_word   = rd_pend ? {{(FRAME_W-DATA_W){1'b0}}, rdata} : '0;
    assign ext_ref_sel = cfg[EXTREF_IDX][EXTREF_BIT];

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !unlocked) |=> ($stable(cfg) && $stable(shd))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(cfg) && $stable(shd) && $stable(wen))); // R4
    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg == shd) |=> !mv_fault); // R9
    AST_PEND_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_pend) |-> $past(frame_done)); // R2
endmodule

// File: rtl/spireg_target.sv
module spireg_target
    import spireg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic [DATA_W-1:0] raw_code,
    input  logic [DATA_W-1:0] filt_code,
    output logic              ext_ref_sel
);
    logic [2:0]         pin_q, pin_rise, pin_fall;
    logic               frame_done, frame_ok;
    frame_t             rx_word;
    logic [FRAME_W-1:0] load_word;

    spireg_pin_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (3),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({mosi, cs_n, sclk}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    spireg_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .selected   (~pin_q[1]),
        .sclk_rise  (pin_rise[0]),
        .sclk_fall  (pin_fall[0]),
        .cs_fall    (pin_fall[1]),
        .cs_rise    (pin_rise[1]),
        .mosi_q     (pin_q[2]),
        .load_word  (load_word),
        .frame_done (frame_done),
        .frame_ok   (frame_ok),
        .rx_word    (rx_word),
        .miso       (miso)
    );

    spireg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .frame_done  (frame_done),
        .frame_ok    (frame_ok),
        .rx_word     (rx_word),
        .raw_code    (raw_code),
        .filt_code   (filt_code),
        .load_word   (load_word),
        .ext_ref_sel (ext_ref_sel)
    );

    AST_EXTREF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(ext_ref_sel)); // R10
endmodule

// File: tb/spireg_target_bench.sv
`timescale 1ns/1ps
module spireg_target_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [9:0] raw_code = 10'h2A5;
    logic [9:0] filt_code = 10'h15A;
    logic       ext_ref_sel;

    int n_checks = 0;
    int n_err = 0;

    logic [9:0] m_mem [32];
    logic [9:0] m_wen;
    bit         pend_v;
    logic [4:0] pend_a;

    always #2.5 clk = ~clk;

    spireg_target u_spireg_target (
        .clk (clk), .rst (rst), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
        .miso (miso), .raw_code (raw_code), .filt_code (filt_code),
        .ext_ref_sel (ext_ref_sel)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] m_read(input logic [4:0] a);
        logic [9:0] fl;
        fl = '0;
        for (int i = 3; i <= 10; i++) if (m_mem[i] != m_mem[i+16]) fl[0] = 1'b1;
        if (a == 5'h00) return raw_code;
        if (a == 5'h01) return filt_code;
        if (a == 5'h02) return fl;
        if (a == 5'h0C) return m_wen;
        if ((a >= 5'h03 && a <= 5'h0A) || (a >= 5'h13 && a <= 5'h1A)) return m_mem[a];
        return '0;
    endfunction

    task automatic spi_frame(input logic [16:0] w, input int nbits, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[i];
            repeat (6) @(negedge clk);
            if (i < 16) got[i] = miso;
            sclk = 1'b1;
            repeat (6) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        check(miso == 1'b0, "R12 idle miso", {15'b0, miso}, 16'h0);
    endtask

    task automatic xfer(input logic [4:0] a, input bit wr, input logic [9:0] d, input string req);
        logic [15:0] exp, got;
        exp = pend_v ? {6'b0, m_read(pend_a)} : 16'h0;
        spi_frame({1'b0, a, wr, d}, 16, got);
        check(got == exp, req, got, exp);
        if (wr) begin
            if (a == 5'h0C) m_wen = d;
            else if (m_wen == 10'h294 &&
                     ((a >= 5'h03 && a <= 5'h0A) || (a >= 5'h13 && a <= 5'h1A))) m_mem[a] = d;
            pend_v = 1'b0;
        end else begin
            pend_v = 1'b1;
            pend_a = a;
        end
        check(ext_ref_sel == m_mem[9][5], "R10 ext_ref_sel", {15'b0, ext_ref_sel}, {15'b0, m_mem[9][5]});
    endtask

    task automatic partial(input logic [4:0] a, input logic [9:0] d, input int nbits);
        logic [15:0] got;
        spi_frame({1'b0, a, 1'b1, d}, nbits, got);
        pend_v = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) xfer(5'(a), 1'b0, 10'h0, req);
        xfer(5'h0C, 1'b0, 10'h0, req);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        m_wen = '0;
        pend_v = 1'b0;
        pend_a = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(miso == 1'b0, "R12 reset miso", {15'b0, miso}, 16'h0);
        check(ext_ref_sel == 1'b0, "R12 reset ext_ref_sel", {15'b0, ext_ref_sel}, 16'h0);

        // R12 R7 R3: reset contents of every address
        sweep("R12 reset sweep");

        // R5: locked writes to every address are ignored
        for (int a = 0; a < 32; a++) if (a != 12) xfer(5'(a), 1'b1, 10'(10'h3FF ^ a), "R5 locked write");
        sweep("R5 after locked writes");

        // R4 R1: unlock key, read back a non-symmetric value
        xfer(5'h0C, 1'b1, 10'h294, "R4 unlock");
        xfer(5'h0C, 1'b0, 10'h0, "R4 read wen");
        xfer(5'h0C, 1'b0, 10'h0, "R1 lsb-first reply of 0x294");

        // R8 R9: primaries set, twins still zero -> fault
        for (int a = 3; a <= 10; a++) xfer(5'(a), 1'b1, 10'((a * 53 + 33) & 10'h3FF), "R8 cfg write");
        sweep("R9 fault raised");
        for (int a = 3; a <= 9; a++) xfer(5'(a + 16), 1'b1, 10'((a * 53 + 33) & 10'h3FF), "R8 twin write");
        sweep("R8 twins readback");
        xfer(5'h1A, 1'b1, 10'((10 * 53 + 33) & 10'h3FF), "R9 last twin");
        sweep("R9 fault cleared");

        // R6 R7: unwritable addresses while unlocked
        for (int a = 0; a < 32; a++)
            if (!((a >= 3 && a <= 10) || (a >= 19 && a <= 26) || a == 12))
                xfer(5'(a), 1'b1, 10'h3FF, "R6 unwritable write");
        sweep("R6 R7 after unwritable writes");

        // R10: clear bit 5 of 0x09, then match twin
        xfer(5'h09, 1'b1, 10'h1DE, "R10 clear ext ref");
        xfer(5'h02, 1'b0, 10'h0, "R9 flag read");
        xfer(5'h19, 1'b1, 10'h1DE, "R9 twin match");
        xfer(5'h02, 1'b0, 10'h0, "R9 flag read");
        xfer(5'h09, 1'b1, 10'h020, "R10 set ext ref");
        xfer(5'h19, 1'b1, 10'h020, "R9 twin match");

        // R2: reply during write frame, then zero after it
        xfer(5'h03, 1'b0, 10'h0, "R2 request");
        xfer(5'h0C, 1'b1, 10'h294, "R2 reply in write frame");
        xfer(5'h03, 1'b0, 10'h0, "R2 zero after write");
        xfer(5'h00, 1'b0, 10'h0, "R2 reply");

        // R11: short and long frames write nothing and cancel the reply
        xfer(5'h04, 1'b0, 10'h0, "R11 request");
        partial(5'h03, 10'h3FF, 8);
        xfer(5'h03, 1'b0, 10'h0, "R11 cancelled after short frame");
        partial(5'h03, 10'h3FF, 17);
        xfer(5'h03, 1'b0, 10'h0, "R11 cancelled after long frame");
        xfer(5'h03, 1'b0, 10'h0, "R11 cfg unchanged");

        // R4: a non-key value locks
        xfer(5'h0C, 1'b1, 10'h155, "R4 relock");
        xfer(5'h04, 1'b1, 10'h3AA, "R4 write while relocked");
        xfer(5'h04, 1'b0, 10'h0, "R4 readback");
        xfer(5'h0C, 1'b1, 10'h000, "R4 lock with zero");
        xfer(5'h0C, 1'b0, 10'h0, "R4 read wen");

        // R3: conversion inputs at many values
        for (int v = 0; v < 1024; v += 37) begin
            raw_code  = 10'(v);
            filt_code = 10'(~v);
            xfer(5'h00, 1'b0, 10'h0, "R3 raw");
            xfer(5'h01, 1'b0, 10'h0, "R3 raw reply");
            xfer(5'h02, 1'b0, 10'h0, "R3 filt reply");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule